// File: doc/BRIEF.md
# Way-Predicted Two-Way Cache Lookup

This block holds the tags, valid bits and data of a small two-way set-associative cache and answers CPU accesses with a single tag comparator. Each set keeps one prediction bit that names the way to probe first. If the predicted way holds the line, the access completes in one cycle, as fast as a direct-mapped lookup. If it does not, the other way is probed in the next cycle. If that probe also fails, the block fetches the word from the next memory level and installs it in a victim way.

Each line holds one data word. Reads that miss in both ways allocate a line. Writes go through to the next level on a write port that has no handshake. A write that hits also updates the cached copy, and a write that misses does not allocate. Only one access is in progress at a time, and `req_ready` stays low until the current access has answered. Because a line may sit in either way and the victim is picked the same way an ordinary two-way cache picks it, prediction changes only latency and never which lines are resident.

Top module: `wpred_cache`

## Requirements
- R1: After reset every line is invalid, every prediction bit selects way 0, `req_ready` is 1, and `rsp_valid` and `mem_rd_valid` are 0. A reset in the middle of operation makes every later read miss.
- R2: A request accepted while the predicted way holds its tag produces `rsp_valid` one cycle after acceptance (latency 1) and issues no next-level read.
- R3: A request whose predicted way misses but whose other way hits responds with latency 2, with the data of the other way.
- R4: On a second-probe hit, the prediction bit of that set changes to the way that hit, so an immediate repeat of the same access has latency 1.
- R5: When both probes fail for a read, `mem_rd_valid` rises in the cycle after the second probe, carrying the request address on `mem_rd_addr`. Both stay stable until the cycle in which `mem_rd_ready` is 1.
- R6: On a refill, the response data equals `mem_rsp_data` and `rsp_valid` rises one cycle after `mem_rsp_valid`. The prediction bit then names the filled way, so a repeat of the access has latency 1.
- R7: The refill victim is an invalid way, way 0 first. If both ways are valid, the victim is the way not used most recently, where a hit or a fill counts as use.
- R8: `req_ready` is 0 from the cycle after a first-probe miss until the response appears. After a first-probe hit, `req_ready` stays 1, so a new request can be accepted in the same cycle the previous response is shown.
- R9: A write pulses `mem_wr_valid` in its acceptance cycle with the request address and data. A write hit updates the cached word and answers with the hit latency. A write miss answers with latency 2, issues no read and allocates nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | CPU request present |
| req_ready | output | 1 | Block can accept a request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address; low log2(SETS) bits select the set |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_rdata | output | DATA_W | Read data, or echoed write data on a write |
| mem_rd_valid | output | 1 | Next-level read request |
| mem_rd_ready | input | 1 | Next level takes the read request |
| mem_rd_addr | output | ADDR_W | Next-level read address |
| mem_rsp_valid | input | 1 | Next-level read data strobe |
| mem_rsp_data | input | DATA_W | Next-level read data |
| mem_wr_valid | output | 1 | Write-through strobe |
| mem_wr_addr | output | ADDR_W | Write-through address |
| mem_wr_data | output | DATA_W | Write-through data |

## Verification
Two things can fall in the same cycle: the response to one access, and the first probe of the next access, which is also its acceptance. The bench provokes this by holding `req_valid` high across two first-probe hits to different sets. It then expects the first response and a high `req_ready` in the same cycle, followed by the second response one cycle later with its own data. A second-probe hit updates the prediction bit and the use bit of a set on the edge where it responds, and a repeated access after it must show latency 1. The bench judges this by counting latency from acceptance to response.

// File: rtl/wpc_pkg.sv
package wpc_pkg;

    localparam int NUM_WAYS = 2;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_PROBE2,
        ST_FETCH,
        ST_FILL
    } wpc_state_e;

    // request to mark a way as most recently used and predicted
    typedef struct packed {
        logic en;
        logic way;
    } wpc_touch_t;

    function automatic logic other_way(input logic w);
        return ~w;
    endfunction

    // invalid way first (way 0 before way 1), otherwise the LRU pointer
    function automatic logic pick_victim(input logic [NUM_WAYS-1:0] vld, input logic lru);
        if (!vld[0]) return 1'b0;
        if (!vld[1]) return 1'b1;
        return lru;
    endfunction

endpackage

// File: rtl/wpc_tag_store.sv
module wpc_tag_store
    import wpc_pkg::*;
#(
    parameter int SETS  = 16,
    parameter int TAG_W = 12,
    localparam int IDX_W = $clog2(SETS)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [IDX_W-1:0]    rd_idx,
    input  logic                rd_way,
    output logic                rd_valid,
    output logic [TAG_W-1:0]    rd_tag,
    output logic [NUM_WAYS-1:0] set_valid,
    input  logic                wr_en,
    input  logic [IDX_W-1:0]    wr_idx,
    input  logic                wr_way,
    input  logic [TAG_W-1:0]    wr_tag
);

    logic [NUM_WAYS-1:0][TAG_W-1:0] way_tag;

    for (genvar g = 0; g < NUM_WAYS; g++) begin : g_way
        logic [TAG_W-1:0] tag_q [SETS];
        logic [SETS-1:0]  vld_q;
        logic             sel;

        assign sel = wr_en && (wr_way == 1'(g));

        always_ff @(posedge clk) begin
            if (rst) begin
                vld_q <= '0;
            end else if (sel) begin
                vld_q[wr_idx] <= 1'b1;
            end
        end

        always_ff @(posedge clk) begin
            if (sel) begin
                tag_q[wr_idx] <= wr_tag;
            end
        end

        assign way_tag[g]   = tag_q[rd_idx];
        assign set_valid[g] = vld_q[rd_idx];
    end

    assign rd_tag   = way_tag[rd_way];
    assign rd_valid = set_valid[rd_way];

endmodule

// File: rtl/wpc_data_store.sv
module wpc_data_store
    import wpc_pkg::*;
#(
    parameter int SETS   = 16,
    parameter int DATA_W = 32,
    localparam int IDX_W = $clog2(SETS)
) (
    input  logic              clk,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic              rd_way,
    output logic [DATA_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic              wr_way,
    input  logic [DATA_W-1:0] wr_data
);

    logic [NUM_WAYS-1:0][DATA_W-1:0] way_data;

    for (genvar g = 0; g < NUM_WAYS; g++) begin : g_way
        logic [DATA_W-1:0] word_q [SETS];

        always_ff @(posedge clk) begin
            if (wr_en && (wr_way == 1'(g))) begin
                word_q[wr_idx] <= wr_data;
            end
        end

        assign way_data[g] = word_q[rd_idx];
    end

    assign rd_data = way_data[rd_way];

endmodule

// File: rtl/wpc_set_state.sv
module wpc_set_state
    import wpc_pkg::*;
#(
    parameter int SETS = 16,
    localparam int IDX_W = $clog2(SETS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] idx,
    output logic             pred_bit,
    output logic             lru_bit,
    input  wpc_touch_t       touch
);

    // pred_q: way probed first; lru_q: way to evict next
    logic [SETS-1:0] pred_q;
    logic [SETS-1:0] lru_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pred_q <= '0;
            lru_q  <= '0;
        end else if (touch.en) begin
            pred_q[idx] <= touch.way;
            lru_q[idx]  <= other_way(touch.way);
        end
    end

    assign pred_bit = pred_q[idx];
    assign lru_bit  = lru_q[idx];

endmodule

// File: rtl/wpc_ctrl.sv
module wpc_ctrl
    import wpc_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter int SETS   = 16,
    localparam int IDX_W = $clog2(SETS),
    localparam int TAG_W = ADDR_W - IDX_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic                req_write,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [DATA_W-1:0]   req_wdata,
    output logic                rsp_valid,
    output logic [DATA_W-1:0]   rsp_rdata,
    output logic                mem_rd_valid,
    input  logic                mem_rd_ready,
    output logic [ADDR_W-1:0]   mem_rd_addr,
    input  logic                mem_rsp_valid,
    input  logic [DATA_W-1:0]   mem_rsp_data,
    output logic                mem_wr_valid,
    output logic [ADDR_W-1:0]   mem_wr_addr,
    output logic [DATA_W-1:0]   mem_wr_data,
    output logic [IDX_W-1:0]    set_idx,
    output logic                probe_way,
    input  logic                probe_valid,
    input  logic [TAG_W-1:0]    probe_tag,
    input  logic [NUM_WAYS-1:0] set_valid,
    input  logic [DATA_W-1:0]   probe_data,
    input  logic                pred_bit,
    input  logic                lru_bit,
    output wpc_touch_t          touch,
    output logic                tag_wr_en,
    output logic                tag_wr_way,
    output logic [TAG_W-1:0]    tag_wr_tag,
    output logic                data_wr_en,
    output logic                data_wr_way,
    output logic [DATA_W-1:0]   data_wr_data
);

    wpc_state_e        state_q, state_d;
    logic [ADDR_W-1:0] lat_addr_q;
    logic              lat_wr_q;
    logic [DATA_W-1:0] lat_wdata_q;
    logic              first_way_q;
    logic              rsp_valid_q;
    logic [DATA_W-1:0] rsp_data_q;

    logic [ADDR_W-1:0] cur_addr;
    logic [TAG_W-1:0]  cur_tag;
    logic              cur_wr;
    logic [DATA_W-1:0] cur_wdata;
    logic              probe_hit;
    logic              victim;
    logic              accept;
    logic              rsp_set;
    logic [DATA_W-1:0] rsp_d;

    // the first probe uses the live request, later cycles the latched copy
    assign cur_addr  = (state_q == ST_IDLE) ? req_addr  : lat_addr_q;
    assign cur_wr    = (state_q == ST_IDLE) ? req_write : lat_wr_q;
    assign cur_wdata = (state_q == ST_IDLE) ? req_wdata : lat_wdata_q;
    assign set_idx   = cur_addr[IDX_W-1:0];
    assign cur_tag   = cur_addr[ADDR_W-1:IDX_W];

    assign probe_way = (state_q == ST_IDLE) ? pred_bit : other_way(first_way_q);
    // the single tag comparator of the block
    assign probe_hit = probe_valid && (probe_tag == cur_tag);
    assign victim    = pick_victim(set_valid, lru_bit);

    assign accept    = (state_q == ST_IDLE) && req_valid;
    assign req_ready = (state_q == ST_IDLE);

    always_comb begin
        state_d      = state_q;
        rsp_set      = 1'b0;
        rsp_d        = '0;
        touch        = '{en: 1'b0, way: 1'b0};
        tag_wr_en    = 1'b0;
        tag_wr_way   = victim;
        tag_wr_tag   = cur_tag;
        data_wr_en   = 1'b0;
        data_wr_way  = probe_way;
        data_wr_data = cur_wdata;
        unique case (state_q)
            ST_IDLE, ST_PROBE2: begin
                if ((state_q == ST_PROBE2) || accept) begin
                    if (probe_hit) begin
                        rsp_set    = 1'b1;
                        rsp_d      = cur_wr ? cur_wdata : probe_data;
                        touch      = '{en: 1'b1, way: probe_way};
                        data_wr_en = cur_wr;
                        state_d    = ST_IDLE;
                    end else if (state_q == ST_IDLE) begin
                        state_d = ST_PROBE2;
                    end else if (lat_wr_q) begin
                        rsp_set = 1'b1;
                        rsp_d   = lat_wdata_q;
                        state_d = ST_IDLE;
                    end else begin
                        state_d = ST_FETCH;
                    end
                end
            end
            ST_FETCH: begin
                if (mem_rd_ready) begin
                    state_d = ST_FILL;
                end
            end
            ST_FILL: begin
                if (mem_rsp_valid) begin
                    rsp_set      = 1'b1;
                    rsp_d        = mem_rsp_data;
                    tag_wr_en    = 1'b1;
                    data_wr_en   = 1'b1;
                    data_wr_way  = victim;
                    data_wr_data = mem_rsp_data;
                    touch        = '{en: 1'b1, way: victim};
                    state_d      = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_IDLE;
            rsp_valid_q <= 1'b0;
        end else begin
            state_q     <= state_d;
            rsp_valid_q <= rsp_set;
        end
    end

    always_ff @(posedge clk) begin
        if (accept) begin
            lat_addr_q  <= req_addr;
            lat_wr_q    <= req_write;
            lat_wdata_q <= req_wdata;
            first_way_q <= pred_bit;
        end
        if (rsp_set) begin
            rsp_data_q <= rsp_d;
        end
    end

    assign rsp_valid    = rsp_valid_q;
    assign rsp_rdata    = rsp_data_q;
    assign mem_rd_valid = (state_q == ST_FETCH);
    assign mem_rd_addr  = lat_addr_q;
    assign mem_wr_valid = accept && req_write;
    assign mem_wr_addr  = req_addr;
    assign mem_wr_data  = req_wdata;

endmodule

// File: rtl/wpred_cache.sv
module wpred_cache
    import wpc_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter int SETS   = 16,
    localparam int IDX_W = $clog2(SETS),
    localparam int TAG_W = ADDR_W - IDX_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              mem_rd_valid,
    input  logic              mem_rd_ready,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic              mem_rsp_valid,
    input  logic [DATA_W-1:0] mem_rsp_data,
    output logic              mem_wr_valid,
    output logic [ADDR_W-1:0] mem_wr_addr,
    output logic [DATA_W-1:0] mem_wr_data
);

    logic [IDX_W-1:0]    set_idx;
    logic                probe_way;
    logic                probe_valid;
    logic [TAG_W-1:0]    probe_tag;
    logic [NUM_WAYS-1:0] set_valid;
    logic [DATA_W-1:0]   probe_data;
    logic                pred_bit;
    logic                lru_bit;
    wpc_touch_t          touch;
    logic                tag_wr_en;
    logic                tag_wr_way;
    logic [TAG_W-1:0]    tag_wr_tag;
    logic                data_wr_en;
    logic                data_wr_way;
    logic [DATA_W-1:0]   data_wr_data;

    wpc_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SETS(SETS)) i_ctrl (
        .clk          (clk),
        .rst          (rst),
        .req_valid    (req_valid),
        .req_ready    (req_ready),
        .req_write    (req_write),
        .req_addr     (req_addr),
        .req_wdata    (req_wdata),
        .rsp_valid    (rsp_valid),
        .rsp_rdata    (rsp_rdata),
        .mem_rd_valid (mem_rd_valid),
        .mem_rd_ready (mem_rd_ready),
        .mem_rd_addr  (mem_rd_addr),
        .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data (mem_rsp_data),
        .mem_wr_valid (mem_wr_valid),
        .mem_wr_addr  (mem_wr_addr),
        .mem_wr_data  (mem_wr_data),
        .set_idx      (set_idx),
        .probe_way    (probe_way),
        .probe_valid  (probe_valid),
        .probe_tag    (probe_tag),
        .set_valid    (set_valid),
        .probe_data   (probe_data),
        .pred_bit     (pred_bit),
        .lru_bit      (lru_bit),
        .touch        (touch),
        .tag_wr_en    (tag_wr_en),
        .tag_wr_way   (tag_wr_way),
        .tag_wr_tag   (tag_wr_tag),
        .data_wr_en   (data_wr_en),
        .data_wr_way  (data_wr_way),
        .data_wr_data (data_wr_data)
    );

    wpc_tag_store #(.SETS(SETS), .TAG_W(TAG_W)) i_tags (
        .clk      (clk),
        .rst      (rst),
        .rd_idx   (set_idx),
        .rd_way   (probe_way),
        .rd_valid (probe_valid),
        .rd_tag   (probe_tag),
        .set_valid(set_valid),
        .wr_en    (tag_wr_en),
        .wr_idx   (set_idx),
        .wr_way   (tag_wr_way),
        .wr_tag   (tag_wr_tag)
    );

    wpc_data_store #(.SETS(SETS), .DATA_W(DATA_W)) i_data (
        .clk    (clk),
        .rd_idx (set_idx),
        .rd_way (probe_way),
        .rd_data(probe_data),
        .wr_en  (data_wr_en),
        .wr_idx (set_idx),
        .wr_way (data_wr_way),
        .wr_data(data_wr_data)
    );

    wpc_set_state #(.SETS(SETS)) i_state (
        .clk     (clk),
        .rst     (rst),
        .idx     (set_idx),
        .pred_bit(pred_bit),
        .lru_bit (lru_bit),
        .touch   (touch)
    );

endmodule

// File: rtl/wpc_chk.sv
module wpc_chk #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic [DATA_W-1:0] rsp_rdata,
    input logic              mem_rd_valid,
    input logic              mem_rd_ready,
    input logic [ADDR_W-1:0] mem_rd_addr,
    input logic              mem_rsp_valid,
    input logic [DATA_W-1:0] mem_rsp_data
);

    logic rst_d;
    always_ff @(posedge clk) rst_d <= rst;

    // R1
    always_ff @(posedge clk) begin
        if (rst_d && !rst) begin
            reset_idle_chk: assert (req_ready && !rsp_valid && !mem_rd_valid);
        end
    end

    // R5
    miss_req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        mem_rd_valid && !mem_rd_ready |=> mem_rd_valid && $stable(mem_rd_addr));

    // R5
    miss_after_probe2_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_rd_valid) |-> !$past(req_ready) && $past(req_ready, 2));

    // R8
    busy_after_miss_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_ready |=> rsp_valid || !req_ready);

    // R8
    no_rsp_while_fetch_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> !mem_rd_valid);

    // R6
    fill_resp_chk: assert property (@(posedge clk) disable iff (rst)
        mem_rsp_valid && !req_ready && !mem_rd_valid |=>
            rsp_valid && (rsp_rdata == $past(mem_rsp_data)));

endmodule

bind wpred_cache wpc_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_wpc_chk (
    .clk          (clk),
    .rst          (rst),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .rsp_valid    (rsp_valid),
    .rsp_rdata    (rsp_rdata),
    .mem_rd_valid (mem_rd_valid),
    .mem_rd_ready (mem_rd_ready),
    .mem_rd_addr  (mem_rd_addr),
    .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data (mem_rsp_data)
);

// File: tb/test_wpred_cache.sv
module test_wpred_cache;

    localparam int MEM_LAT  = 3;
    localparam int MISS_LAT = 4 + MEM_LAT;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [15:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic        mem_rd_valid;
    logic        mem_rd_ready = 1'b0;
    logic [15:0] mem_rd_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic        mem_wr_valid;
    logic [15:0] mem_wr_addr;
    logic [31:0] mem_wr_data;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    wpred_cache i_wpred_cache (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready), .mem_rd_addr(mem_rd_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .mem_wr_valid(mem_wr_valid), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data)
    );

    // next-level memory model
    logic [31:0] mstore [logic [15:0]];
    int          reads = 0;
    int          stall_left = 0;
    int          cnt = 0;
    logic [15:0] seen_addr = '0;

    function automatic logic [31:0] mval(input logic [15:0] a);
        if (mstore.exists(a)) return mstore[a];
        return {~a, a};
    endfunction

    always @(negedge clk) begin
        if (mem_rsp_valid) mem_rsp_valid = 1'b0;
        if (mem_rd_ready) begin
            mem_rd_ready = 1'b0;
        end else if (cnt > 0) begin
            cnt = cnt - 1;
            if (cnt == 0) begin
                mem_rsp_valid = 1'b1;
                mem_rsp_data  = mval(seen_addr);
            end
        end else if (mem_rd_valid) begin
            if (stall_left == 0) begin
                mem_rd_ready = 1'b1;
                seen_addr    = mem_rd_addr;
                cnt          = MEM_LAT;
                reads        = reads + 1;
            end else begin
                stall_left = stall_left - 1;
            end
        end
    end

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic access(input logic wr, input logic [15:0] a, input logic [31:0] wd,
                          output int lat, output logic [31:0] rd, output int rdy_low, output logic wr_seen);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = wd;
        #1;
        wr_seen = mem_wr_valid && (mem_wr_addr == a) && (mem_wr_data == wd);
        if (mem_wr_valid) mstore[a] = wd;
        @(negedge clk);
        req_valid = 1'b0;
        lat = 0; rdy_low = 0; rd = '0;
        while (1) begin
            lat++;
            if (rsp_valid) begin
                rd = rsp_rdata;
                break;
            end
            if (!req_ready) rdy_low++;
            if (lat > 60) break;
            @(negedge clk);
        end
    endtask

    typedef struct packed {
        logic        wr;
        logic [15:0] addr;
        logic [31:0] wdata;
        logic [3:0]  lat;
        logic        dchk;
        logic        fmem;
        logic [31:0] data;
        logic        rd;
        logic [1:0]  focus;   // 1: prediction follow-up, 2: victim choice
    } vec_t;

    localparam logic [15:0] A = 16'h0013, B = 16'h0023, C = 16'h0033, D = 16'h0045;
    localparam logic [3:0] ML = 4'(MISS_LAT);

    localparam vec_t VECS [15] = '{
        '{1'b0, A, 32'h0, ML,   1'b1, 1'b1, 32'h0,          1'b1, 2'd0}, // cold miss -> way0
        '{1'b0, A, 32'h0, 4'd1, 1'b1, 1'b1, 32'h0,          1'b0, 2'd0},
        '{1'b0, B, 32'h0, ML,   1'b1, 1'b1, 32'h0,          1'b1, 2'd0}, // fills way1
        '{1'b0, B, 32'h0, 4'd1, 1'b1, 1'b1, 32'h0,          1'b0, 2'd0},
        '{1'b0, A, 32'h0, 4'd2, 1'b1, 1'b1, 32'h0,          1'b0, 2'd0}, // second probe
        '{1'b0, A, 32'h0, 4'd1, 1'b1, 1'b1, 32'h0,          1'b0, 2'd1}, // R4
        '{1'b0, C, 32'h0, ML,   1'b1, 1'b1, 32'h0,          1'b1, 2'd0}, // evicts B
        '{1'b0, A, 32'h0, 4'd2, 1'b1, 1'b1, 32'h0,          1'b0, 2'd2}, // R7 A kept
        '{1'b0, B, 32'h0, ML,   1'b1, 1'b1, 32'h0,          1'b1, 2'd2}, // R7 B gone
        '{1'b1, B, 32'hCAFEF00D, 4'd1, 1'b0, 1'b0, 32'h0,   1'b0, 2'd0}, // write hit
        '{1'b0, B, 32'h0, 4'd1, 1'b1, 1'b0, 32'hCAFEF00D,   1'b0, 2'd0},
        '{1'b1, D, 32'h12345678, 4'd2, 1'b0, 1'b0, 32'h0,   1'b0, 2'd0}, // write miss
        '{1'b0, D, 32'h0, ML,   1'b1, 1'b0, 32'h12345678,   1'b1, 2'd0}, // no allocate
        '{1'b0, D, 32'h0, 4'd1, 1'b1, 1'b0, 32'h12345678,   1'b0, 2'd0},
        '{1'b0, A, 32'h0, 4'd2, 1'b1, 1'b1, 32'h0,          1'b0, 2'd0}
    };

    initial begin
        repeat (100000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        int lat, rl, r0;
        logic [31:0] rd;
        logic ws;
        string tg;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state at the ports
        chk("R1", "req_ready", 32'(req_ready), 32'd1);
        chk("R1", "rsp_valid", 32'(rsp_valid), 32'd0);
        chk("R1", "mem_rd_valid", 32'(mem_rd_valid), 32'd0);

        foreach (VECS[i]) begin
            r0 = reads;
            access(VECS[i].wr, VECS[i].addr, VECS[i].wdata, lat, rd, rl, ws);
            if (VECS[i].focus == 2'd1)      tg = "R4";
            else if (VECS[i].focus == 2'd2) tg = "R7";
            else if (VECS[i].wr)            tg = "R9";
            else if (VECS[i].lat == 4'd1)   tg = "R2";
            else if (VECS[i].lat == 4'd2)   tg = "R3";
            else                            tg = "R6";
            chk(tg, $sformatf("latency vec%0d", i), 32'(lat), 32'(VECS[i].lat));
            chk("R5", $sformatf("next-level reads vec%0d", i), 32'(reads - r0), 32'(VECS[i].rd));
            chk("R8", $sformatf("ready-low cycles vec%0d", i), 32'(rl), 32'(VECS[i].lat) - 1);
            chk("R9", $sformatf("write-through vec%0d", i), 32'(ws), 32'(VECS[i].wr));
            if (VECS[i].dchk)
                chk(tg, $sformatf("data vec%0d", i), rd,
                    VECS[i].fmem ? mval(VECS[i].addr) : VECS[i].data);
        end

        // R5: request held while the next level stalls
        stall_left = 2;
        r0 = reads;
        access(1'b0, 16'h0076, 32'h0, lat, rd, rl, ws);
        chk("R5", "stalled miss latency", 32'(lat), 32'(MISS_LAT + 2));
        chk("R5", "miss address", 32'(seen_addr), 32'h0076);
        chk("R5", "one read", 32'(reads - r0), 32'd1);
        chk("R6", "stalled miss data", rd, mval(16'h0076));

        // R8 / R2: back-to-back first-probe hits, response and next probe share a cycle
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = A;
        @(negedge clk);
        chk("R2", "b2b first rsp", 32'(rsp_valid), 32'd1);
        chk("R2", "b2b first data", rsp_rdata, mval(A));
        chk("R8", "b2b ready", 32'(req_ready), 32'd1);
        req_addr = D;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R2", "b2b second rsp", 32'(rsp_valid), 32'd1);
        chk("R2", "b2b second data", rsp_rdata, 32'h12345678);

        // R1: reset mid-run invalidates lines
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        r0 = reads;
        access(1'b0, A, 32'h0, lat, rd, rl, ws);
        chk("R1", "miss after reset", 32'(lat), 32'(MISS_LAT));
        chk("R1", "read after reset", 32'(reads - r0), 32'd1);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule